// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This controller sits beside a static RAM whose cells each have a nonvolatile shadow copy. It decides when a whole-array STORE (RAM to shadow) or RECALL (shadow to RAM) runs, and it times each one. Several sources can ask for a transfer:

- a hardware store pin, which must be held for a minimum number of cycles;
- single-cycle software store and software recall requests;
- a power-fail comparator, which triggers an automatic store;
- a power-up recall that is latched while the supply sits below its reset level.

While any transfer is in progress, the block raises an access-inhibit signal that the RAM port logic uses to block reads and writes. The active-low store-busy output is low only while a STORE is running. One-cycle start strobes tell the array-copy machinery when to begin.

Stores from the pin and from the comparator run only if at least one RAM write has completed since the last transfer. Software stores always run. After each transfer ends, the inhibit stays up for a recovery window. All durations are parameters counted in clock cycles. There is no data path, so every pin is a plain control or status level or pulse, with no handshake.

Top module: `nv_xfer_seq`

## Requirements
- R1: `access_inhibit` is high in every cycle of a hardware-store lead-in, a STORE, a RECALL or a recovery window, and low otherwise; both outputs are idle (`busy_n`=1, `access_inhibit`=0) during reset.
- R2: A STORE drives `busy_n` low for exactly STORE_CYC cycles. `store_start` is high for exactly one cycle, the first cycle of that low period.
- R3: When a STORE or a RECALL ends, `access_inhibit` stays high with `busy_n` high for exactly RECOVER_CYC more cycles before returning low.
- R4: A `sw_store` pulse sampled while idle starts a STORE in the next cycle, whether or not a write has occurred.
- R5: A qualified hardware-pin request or a power-fail rising edge is ignored (no inhibit, no busy) when no write has completed since the last transfer.
- R6: A `wr_done` pulse sampled while idle marks the array as written. A `wr_done` pulse sampled during any active phase has no effect. The written mark is cleared when a STORE or a RECALL ends.
- R7: `hw_store` is accepted only on the HW_MIN_CYC-th consecutive cycle that it is sampled high; a shorter pulse is ignored. On acceptance, a lead-in of HW_LEAD_CYC cycles (inhibit high, `busy_n` high) precedes the STORE.
- R8: A rising edge of `pfail` starts a STORE in the next cycle when the array is marked written and `auto_inhibit` is low. While `auto_inhibit` is high, such an edge is ignored.
- R9: A RECALL, whether from `sw_recall` or from power-up, gives one `recall_start` cycle and keeps `access_inhibit` high for RECALL_CYC + RECOVER_CYC cycles, with `busy_n` held high throughout.
- R10: Reset and any cycle with `low_vreset` high latch a pending recall. That recall starts in the cycle after the first sample with both `low_vreset` and `pfail` low. While the recall is pending, no store starts.
- R11: Any trigger that arrives while a lead-in, transfer or recovery is active is dropped, not queued.
- R12: When triggers coincide while idle, the order of priority is: pending power-up recall, power-fail store, hardware store, software store, software recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_store | input | 1 | Hardware store request level |
| sw_store | input | 1 | Software store request, one-cycle pulse |
| sw_recall | input | 1 | Software recall request, one-cycle pulse |
| pfail | input | 1 | High while supply is below the switch threshold |
| low_vreset | input | 1 | High while supply is below the reset level |
| auto_inhibit | input | 1 | High disables power-fail stores |
| wr_done | input | 1 | Pulse for each completed RAM write |
| busy_n | output | 1 | Low while a STORE runs |
| access_inhibit | output | 1 | High while RAM access must be blocked |
| store_start | output | 1 | One-cycle STORE start strobe |
| recall_start | output | 1 | One-cycle RECALL start strobe |

## Verification
A trigger sampled at a rising edge changes the outputs right after that edge. Software and power-fail triggers therefore show their first inhibit or busy cycle at the next falling edge. A hardware request shows its first cycle one edge after its HW_MIN_CYC-th high sample, and a pending recall one edge after the first sample with both supply flags low. Each scenario releases its stimulus just after the sampling edge. It then counts phase lengths cycle by cycle at falling edges, split into pre-busy, busy and post-busy, and compares each count with the parameter-derived totals. Ignored triggers are confirmed by seeing zero inhibit cycles at the ports.

// File: rtl/nvx_pkg.sv
package nvx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_STORE,
    PH_RECALL,
    PH_RECOVER
  } phase_e;
endpackage

// File: rtl/nvx_trig_qual.sv
// Conditions the hardware store pin (minimum width) and the power-fail edge.
module nvx_trig_qual #(
  parameter int HW_MIN_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_store,
  input  logic pfail,
  output logic hw_hit,
  output logic pf_rise
);
  localparam int QW = $clog2(HW_MIN_CYC + 1);
  localparam logic [QW-1:0] HIT_AT = QW'(HW_MIN_CYC - 1);
  localparam logic [QW-1:0] SAT_AT = QW'(HW_MIN_CYC);

  logic [QW-1:0] hi_cnt;
  logic          pf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      pf_q   <= 1'b0;
    end else begin
      pf_q <= pfail;
      if (!hw_store)
        hi_cnt <= '0;
      else if (hi_cnt != SAT_AT)
        hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assign hw_hit  = hw_store && (hi_cnt == HIT_AT);
  assign pf_rise = pfail && !pf_q;
endmodule

// File: rtl/nvx_flags.sv
// Written-since-transfer mark and latched power-up recall request.
module nvx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_done,
  input  logic idle,
  input  logic xfer_end,
  input  logic low_vreset,
  input  logic recall_take,
  output logic dirty,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty <= 1'b0;
      pend  <= 1'b1;
    end else begin
      if (xfer_end)
        dirty <= 1'b0;
      else if (wr_done && idle)
        dirty <= 1'b1;
      if (low_vreset)
        pend <= 1'b1;
      else if (recall_take)
        pend <= 1'b0;
    end
  end
endmodule

// File: rtl/nvx_phase_timer.sv
// Down-counter: loaded on phase entry, expired on the last cycle of a phase.
module nvx_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq
  import nvx_pkg::*;
#(
  parameter int STORE_CYC   = 500000,
  parameter int RECALL_CYC  = 1000,
  parameter int RECOVER_CYC = 35,
  parameter int HW_LEAD_CYC = 15,
  parameter int HW_MIN_CYC  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_store,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic pfail,
  input  logic low_vreset,
  input  logic auto_inhibit,
  input  logic wr_done,
  output logic busy_n,
  output logic access_inhibit,
  output logic store_start,
  output logic recall_start
);
  localparam int M1 = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int M2 = (RECOVER_CYC > HW_LEAD_CYC) ? RECOVER_CYC : HW_LEAD_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MAXC + 1);

  phase_e        ph, nxt;
  logic          hw_hit, pf_rise, dirty, pend, expired;
  logic          load, recall_take, xfer_end, idle;
  logic [CW-1:0] load_val;

  nvx_trig_qual #(.HW_MIN_CYC(HW_MIN_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .hw_store(hw_store), .pfail(pfail),
    .hw_hit(hw_hit), .pf_rise(pf_rise)
  );

  nvx_flags u_flags (
    .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .idle(idle),
    .xfer_end(xfer_end), .low_vreset(low_vreset), .recall_take(recall_take),
    .dirty(dirty), .pend(pend)
  );

  nvx_phase_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .expired(expired)
  );

  assign idle     = (ph == PH_IDLE);
  assign xfer_end = ((ph == PH_STORE) || (ph == PH_RECALL)) && expired;

  always_comb begin
    nxt         = ph;
    recall_take = 1'b0;
    unique case (ph)
      PH_IDLE: begin
        if (pend) begin
          if (!low_vreset && !pfail) begin
            nxt         = PH_RECALL;
            recall_take = 1'b1;
          end
        end else if (pf_rise && !auto_inhibit && dirty)
          nxt = PH_STORE;
        else if (hw_hit && dirty)
          nxt = PH_LEAD;
        else if (sw_store)
          nxt = PH_STORE;
        else if (sw_recall)
          nxt = PH_RECALL;
      end
      PH_LEAD:    if (expired) nxt = PH_STORE;
      PH_STORE:   if (expired) nxt = PH_RECOVER;
      PH_RECALL:  if (expired) nxt = PH_RECOVER;
      PH_RECOVER: if (expired) nxt = PH_IDLE;
      default:    nxt = PH_IDLE;
    endcase
  end

  assign load = (nxt != ph);

  always_comb begin
    unique case (nxt)
      PH_LEAD:    load_val = CW'(HW_LEAD_CYC - 1);
      PH_STORE:   load_val = CW'(STORE_CYC - 1);
      PH_RECALL:  load_val = CW'(RECALL_CYC - 1);
      PH_RECOVER: load_val = CW'(RECOVER_CYC - 1);
      default:    load_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph           <= PH_IDLE;
      store_start  <= 1'b0;
      recall_start <= 1'b0;
    end else begin
      ph           <= nxt;
      store_start  <= (nxt == PH_STORE) && (ph != PH_STORE);
      recall_start <= (nxt == PH_RECALL) && (ph != PH_RECALL);
    end
  end

  assign busy_n         = (ph != PH_STORE);
  assign access_inhibit = (ph != PH_IDLE);
endmodule

// File: rtl/nvx_seq_chk.sv
module nvx_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_n,
  input logic inhibit,
  input logic store_start,
  input logic recall_start
);
  // R1: store busy always blocks access
  p_busy_inhibits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> inhibit);
  // R2: busy only falls together with the store strobe
  p_busy_fall_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> store_start);
  // R3: busy release is followed by recovery, not immediate access
  p_recover_after_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> inhibit);
  // R3: inhibit drops only after a non-busy cycle
  p_inhibit_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inhibit) |-> (busy_n && $past(busy_n)));
  // R9: recall strobe with inhibit up and busy high
  p_recall_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start |-> (inhibit && busy_n));
  // R12: never both transfers at once
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_start, recall_start}));
endmodule

bind nv_xfer_seq nvx_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .inhibit(access_inhibit),
  .store_start(store_start), .recall_start(recall_start)
);

// File: tb/nv_xfer_seq_test.sv
module nv_xfer_seq_test;
  localparam int ST = 20, RC = 8, RV = 4, LD = 3, HM = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hw_store = 0, sw_store = 0, sw_recall = 0, pfail = 0;
  logic low_vreset = 0, auto_inhibit = 0, wr_done = 0;
  logic busy_n, access_inhibit, store_start, recall_start;
  int checks = 0, fails = 0;
  int pre, bsy, post, ns, nr;

  always #10 clk = ~clk;

  nv_xfer_seq #(.STORE_CYC(ST), .RECALL_CYC(RC), .RECOVER_CYC(RV),
                .HW_LEAD_CYC(LD), .HW_MIN_CYC(HM)) uut (
    .clk(clk), .rst_n(rst_n), .hw_store(hw_store), .sw_store(sw_store),
    .sw_recall(sw_recall), .pfail(pfail), .low_vreset(low_vreset),
    .auto_inhibit(auto_inhibit), .wr_done(wr_done), .busy_n(busy_n),
    .access_inhibit(access_inhibit), .store_start(store_start),
    .recall_start(recall_start));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count phase lengths at falling edges until inhibit drops.
  task automatic observe();
    bit seen_busy = 0;
    pre = 0; bsy = 0; post = 0; ns = 0; nr = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!access_inhibit) break;
      if (store_start) ns++;
      if (recall_start) nr++;
      if (!busy_n) begin bsy++; seen_busy = 1; end
      else if (!seen_busy) pre++;
      else post++;
    end
  endtask

  task automatic do_write();
    @(negedge clk); wr_done = 1; @(posedge clk); #1 wr_done = 0;
  endtask

  task automatic t_reset_powerup();
    repeat (3) @(negedge clk);
    check("R1 reset busy_n", busy_n, 1);
    check("R1 reset inhibit", access_inhibit, 0);
    rst_n = 1;
    observe();
    check("R9 powerup recall len", pre, RC + RV);
    check("R9 powerup busy", bsy, 0);
    check("R10 powerup recall strobe", nr, 1);
  endtask

  task automatic t_sw_store_clean();
    @(negedge clk); sw_store = 1; @(posedge clk); #1 sw_store = 0;
    observe();
    check("R4 sw store runs clean", bsy, ST);
    check("R2 store strobe", ns, 1);
    check("R1 no lead", pre, 0);
    check("R3 recovery", post, RV);
  endtask

  task automatic t_clean_ignored();
    @(negedge clk); hw_store = 1; repeat (HM) @(posedge clk); #1 hw_store = 0;
    observe();
    check("R5 hw ignored clean", pre + bsy + post, 0);
    @(negedge clk); pfail = 1; @(posedge clk); #1;
    observe();
    check("R5 pfail ignored clean", pre + bsy + post, 0);
    pfail = 0;
  endtask

  task automatic t_hw_pin();
    do_write();
    @(negedge clk); hw_store = 1; repeat (HM - 1) @(posedge clk); #1 hw_store = 0;
    observe();
    check("R7 short pulse ignored", pre + bsy + post, 0);
    @(negedge clk); hw_store = 1; repeat (HM) @(posedge clk); #1 hw_store = 0;
    observe();
    check("R7 hw lead-in", pre, LD);
    check("R7 hw store busy", bsy, ST);
    check("R3 hw recovery", post, RV);
    @(negedge clk); hw_store = 1; repeat (HM) @(posedge clk); #1 hw_store = 0;
    observe();
    check("R6 mark cleared by store", pre + bsy + post, 0);
  endtask

  task automatic t_pfail();
    do_write();
    @(negedge clk); auto_inhibit = 1; pfail = 1; @(posedge clk); #1;
    observe();
    check("R8 auto inhibit blocks", pre + bsy + post, 0);
    @(negedge clk); pfail = 0; auto_inhibit = 0;
    @(negedge clk); pfail = 1; @(posedge clk); #1;
    observe();
    check("R8 pfail store busy", bsy, ST);
    check("R8 pfail no lead", pre, 0);
    pfail = 0;
  endtask

  task automatic t_busy_drops();
    @(negedge clk); sw_store = 1; @(posedge clk); #1 sw_store = 0;
    repeat (3) @(negedge clk);
    wr_done = 1; sw_recall = 1; @(posedge clk); #1 wr_done = 0; sw_recall = 0;
    observe();
    check("R11 recall dropped", nr, 0);
    check("R3 recovery after store", post, RV);
    repeat (3) @(negedge clk);
    check("R11 nothing queued", access_inhibit, 0);
    @(negedge clk); hw_store = 1; repeat (HM) @(posedge clk); #1 hw_store = 0;
    observe();
    check("R6 write during busy ignored", pre + bsy + post, 0);
  endtask

  task automatic t_sw_recall_and_priority();
    @(negedge clk); sw_recall = 1; @(posedge clk); #1 sw_recall = 0;
    observe();
    check("R9 sw recall len", pre, RC + RV);
    check("R9 sw recall busy", bsy, 0);
    check("R9 sw recall strobe", nr, 1);
    do_write();
    @(negedge clk); sw_store = 1; sw_recall = 1; @(posedge clk); #1 sw_store = 0; sw_recall = 0;
    observe();
    check("R12 store over recall", ns, 1);
    check("R12 recall lost", nr, 0);
  endtask

  task automatic t_low_voltage();
    @(negedge clk); auto_inhibit = 1; pfail = 1; low_vreset = 1;
    repeat (3) @(negedge clk);
    check("R10 no recall while low", access_inhibit, 0);
    low_vreset = 0;
    repeat (4) @(negedge clk);
    check("R10 waits for pfail low", access_inhibit, 0);
    pfail = 0; @(posedge clk); #1;
    observe();
    check("R10 latched recall runs", nr, 1);
    check("R10 latched recall len", pre, RC + RV);
    auto_inhibit = 0;
    do_write();
    @(negedge clk); low_vreset = 1;
    @(negedge clk); low_vreset = 0; sw_store = 1; @(posedge clk); #1 sw_store = 0;
    observe();
    check("R12 pending recall wins", nr, 1);
    check("R10 store blocked by pending", ns, 0);
  endtask

  initial begin
    t_reset_powerup();
    t_sw_store_clean();
    t_clean_ignored();
    t_hw_pin();
    t_pfail();
    t_busy_drops();
    t_sw_recall_and_priority();
    t_low_voltage();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule